// File: doc/BRIEF.md
# Flash Boot-Block Protection Register Bank

This block is the small register bank that guards the boot area of an on-chip flash array. Software reaches it over a simple synchronous register bus (address, write strobe, write data, combinational read data). It holds three byte-wide registers: a lock register, a configuration register carrying the boot-protect bit, and a test register whose bits drive stress and diagnostic circuitry elsewhere. The flash cells, pumps and timing logic live outside and only consume the exported bits.

The lock bit can be set once per reset in normal operation, and once it is set the configuration register no longer accepts writes. The boot-protect bit also refuses changes while the array's program-enable status is active. A special (test) mode input relaxes the write-once rule and opens the test register, which otherwise reads as zero and ignores writes.

Each program or erase request is screened in the same cycle: when boot protect is set and the request address lies in the boot window, an inhibit signal is raised. The window is the top 2 KB or 1 KB of the lower or upper half of the array address space, chosen by two static pins.

Top module: `flash_guard_regs`

## Requirements
- R1: Register offsets are lock = 0, configuration = 1, test = 2; read data follows the bus address in the same cycle, and bits 7..1 of the lock and configuration registers read as 0.
- R2: After reset the lock bit is 0, the boot-protect bit is 1 and the test register is 0x00.
- R3: In normal mode only the first write to offset 0 after reset is taken (bit 0 loads the lock bit); every later normal-mode write to offset 0 is ignored until the next reset.
- R4: In special mode every write to offset 0 loads bit 0 into the lock bit.
- R5: A write to offset 1 loads bit 0 into boot protect only when the lock bit is 0 and program-enable is low; otherwise boot protect keeps its value.
- R6: The inhibit output is high in the same cycle as a request exactly when the request is valid, boot protect is 1 and the address is inside the boot window.
- R7: The boot window is 0x7800-0x7FFF (map_high=0) or 0xF800-0xFFFF (map_high=1) when small_boot=0, and 0x7C00-0x7FFF or 0xFC00-0xFFFF when small_boot=1.
- R8: In special mode a write to offset 2 stores all eight bits, which read back and appear on the test output; in normal mode writes to offset 2 are dropped and both the read value and the test output are 0x00.
- R9: Offset 3 reads 0x00 and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| special_mode | input | 1 | 1 = special/test mode, 0 = normal mode |
| prog_en | input | 1 | Program/erase enable status from the array controller |
| map_high | input | 1 | Array mapped in upper half when 1 |
| small_boot | input | 1 | 1 = 1 KB boot block, 0 = 2 KB |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| req_valid | input | 1 | Program or erase request present |
| req_addr | input | 16 | Array address of the request |
| req_inhibit | output | 1 | Request blocked by boot protection |
| boot_protect | output | 1 | Boot-protect bit |
| lock_state | output | 1 | Lock bit |
| test_bits | output | 8 | Test control bits (zero outside special mode) |

## Verification
A lost write-once flag shows up as a lock bit that flips on the second normal-mode write, visible on the next read of offset 0 one cycle after the strobe. A wrong lock or program-enable gate appears as a boot-protect value that changes when it should not, visible both on reads of offset 1 and on the same-cycle inhibit decision for a boot-window address. Window decode faults show at once on req_inhibit for addresses one below and at the window edges in each of the four map and size settings.

// File: rtl/fgr_pkg.sv
`timescale 1ns/1ps
package fgr_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SEL_LOCK = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_TEST = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // Offset decode; offsets above 2 fall into SEL_NONE.
  function automatic reg_sel_e decode_offset(input logic [1:0] ofs);
    case (ofs)
      2'd0:    return SEL_LOCK;
      2'd1:    return SEL_CFG;
      2'd2:    return SEL_TEST;
      default: return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/fgr_lock_reg.sv
`timescale 1ns/1ps
module fgr_lock_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic special_mode,
  input  logic wr_hit,
  input  logic wbit,
  output logic lock_q,
  output logic used_q,
  output logic take_ev
);
  // A write is taken in special mode always, in normal mode only before first use.
  assign take_ev = wr_hit && (special_mode || !used_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      used_q <= 1'b0;
    end else begin
      if (take_ev) lock_q <= wbit;
      if (wr_hit && !special_mode) used_q <= 1'b1;
    end
  end
endmodule

// File: rtl/fgr_cfg_reg.sv
`timescale 1ns/1ps
module fgr_cfg_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic wbit,
  input  logic lock_q,
  input  logic prog_en,
  output logic bootp_q,
  output logic take_ev
);
  assign take_ev = wr_hit && !lock_q && !prog_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bootp_q <= 1'b1;
    else if (take_ev) bootp_q <= wbit;
  end
endmodule

// File: rtl/fgr_test_reg.sv
`timescale 1ns/1ps
module fgr_test_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          special_mode,
  input  logic          wr_hit,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] view,
  output logic          take_ev
);
  logic [DW-1:0] store_q;

  assign take_ev = wr_hit && special_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       store_q <= '0;
    else if (take_ev) store_q <= wdata;
  end

  // Outside special mode the register is invisible and exports nothing.
  assign view = special_mode ? store_q : '0;
endmodule

// File: rtl/fgr_boot_window.sv
`timescale 1ns/1ps
module fgr_boot_window #(
  parameter int AW      = 16,
  parameter int BIG_W   = 11,
  parameter int SMALL_W = 10,
  localparam int SW     = AW - SMALL_W
) (
  input  logic [SW-1:0] addr_hi,
  input  logic          map_high,
  input  logic          small_boot,
  input  logic          req_valid,
  input  logic          bootp,
  output logic          hit,
  output logic          inhibit
);
  // addr_hi holds array address bits AW-1 down to SMALL_W.
  function automatic logic in_window(input logic [SW-1:0] a, input logic hi, input logic sm);
    logic half_ok, top_small, top_big;
    half_ok   = (a[SW-1] == hi);
    top_small = &a[SW-2:0];
    top_big   = &a[SW-2:BIG_W-SMALL_W];
    return half_ok && (sm ? top_small : top_big);
  endfunction

  assign hit     = in_window(addr_hi, map_high, small_boot);
  assign inhibit = req_valid && bootp && hit;
endmodule

// File: rtl/flash_guard_regs.sv
`timescale 1ns/1ps
module flash_guard_regs #(
  parameter int REG_AW  = 2,
  parameter int ARR_AW  = 16,
  parameter int BIG_W   = 11,
  parameter int SMALL_W = 10,
  localparam int DW     = fgr_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              special_mode,
  input  logic              prog_en,
  input  logic              map_high,
  input  logic              small_boot,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              req_valid,
  input  logic [ARR_AW-1:0] req_addr,
  output logic              req_inhibit,
  output logic              boot_protect,
  output logic              lock_state,
  output logic [DW-1:0]     test_bits
);
  import fgr_pkg::*;

  reg_sel_e sel;
  logic     wr_lock, wr_cfg, wr_test;
  logic     lock_used;
  logic     lock_take, cfg_take, test_take;
  logic     boot_hit;
  logic     unused_addr_lo;

  assign sel     = decode_offset(bus_addr);
  assign wr_lock = bus_wr && (sel == SEL_LOCK);
  assign wr_cfg  = bus_wr && (sel == SEL_CFG);
  assign wr_test = bus_wr && (sel == SEL_TEST);

  fgr_lock_reg u_lock (
    .clk          (clk),
    .rst_n        (rst_n),
    .special_mode (special_mode),
    .wr_hit       (wr_lock),
    .wbit         (bus_wdata[0]),
    .lock_q       (lock_state),
    .used_q       (lock_used),
    .take_ev      (lock_take)
  );

  fgr_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_hit  (wr_cfg),
    .wbit    (bus_wdata[0]),
    .lock_q  (lock_state),
    .prog_en (prog_en),
    .bootp_q (boot_protect),
    .take_ev (cfg_take)
  );

  fgr_test_reg #(.DW(DW)) u_test (
    .clk          (clk),
    .rst_n        (rst_n),
    .special_mode (special_mode),
    .wr_hit       (wr_test),
    .wdata        (bus_wdata),
    .view         (test_bits),
    .take_ev      (test_take)
  );

  fgr_boot_window #(.AW(ARR_AW), .BIG_W(BIG_W), .SMALL_W(SMALL_W)) u_win (
    .addr_hi    (req_addr[ARR_AW-1:SMALL_W]),
    .map_high   (map_high),
    .small_boot (small_boot),
    .req_valid  (req_valid),
    .bootp      (boot_protect),
    .hit        (boot_hit),
    .inhibit    (req_inhibit)
  );

  assign unused_addr_lo = ^{req_addr[SMALL_W-1:0], boot_hit, lock_take, cfg_take, test_take};

  always_comb begin
    case (sel)
      SEL_LOCK: bus_rdata = {{(DW-1){1'b0}}, lock_state};
      SEL_CFG:  bus_rdata = {{(DW-1){1'b0}}, boot_protect};
      SEL_TEST: bus_rdata = test_bits;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/fgr_checker.sv
`timescale 1ns/1ps
module fgr_checker #(
  parameter int REG_AW = 2,
  parameter int DW     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              special_mode,
  input logic              prog_en,
  input logic [REG_AW-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DW-1:0]     bus_wdata,
  input logic [DW-1:0]     bus_rdata,
  input logic              req_valid,
  input logic              req_inhibit,
  input logic              boot_protect,
  input logic              lock_state,
  input logic [DW-1:0]     test_bits,
  input logic              lock_used
);
  // R3: once the write-once flag is up in normal mode the lock bit holds.
  p_lock_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_used && !special_mode) |=> $stable(lock_state));

  // R4: special-mode lock writes always land.
  p_lock_special_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (special_mode && bus_wr && bus_addr == '0) |=> (lock_state == $past(bus_wdata[0])));

  // R5: boot protect frozen while locked or program-enable is active.
  p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_state || prog_en) |=> $stable(boot_protect));

  // R6: inhibit only for a valid request with boot protect on.
  p_inhibit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_inhibit |-> (req_valid && boot_protect));

  // R8: test bits hidden in normal mode.
  p_test_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !special_mode |-> (test_bits == '0));

  // R9: unmapped offset reads zero.
  p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == {REG_AW{1'b1}}) |-> (bus_rdata == '0));
endmodule

bind flash_guard_regs fgr_checker #(.REG_AW(REG_AW), .DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .special_mode (special_mode),
  .prog_en      (prog_en),
  .bus_addr     (bus_addr),
  .bus_wr       (bus_wr),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .req_valid    (req_valid),
  .req_inhibit  (req_inhibit),
  .boot_protect (boot_protect),
  .lock_state   (lock_state),
  .test_bits    (test_bits),
  .lock_used    (lock_used)
);

// File: tb/sim_flash_guard_regs.sv
`timescale 1ns/1ps
module sim_flash_guard_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        special_mode = 1'b0;
  logic        prog_en = 1'b0;
  logic        map_high = 1'b0;
  logic        small_boot = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = 16'h0000;
  logic        req_inhibit;
  logic        boot_protect;
  logic        lock_state;
  logic [7:0]  test_bits;

  always #2 clk = ~clk;   // 250 MHz

  flash_guard_regs u0 (
    .clk(clk), .rst_n(rst_n), .special_mode(special_mode), .prog_en(prog_en),
    .map_high(map_high), .small_boot(small_boot), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .req_valid(req_valid), .req_addr(req_addr), .req_inhibit(req_inhibit),
    .boot_protect(boot_protect), .lock_state(lock_state), .test_bits(test_bits)
  );

  // Scoreboard item: which output, expected value, requirement tag.
  typedef enum int {OBS_RDATA, OBS_INHIBIT, OBS_BOOTP, OBS_TEST} obs_e;
  typedef struct { obs_e sel; logic [7:0] exp; string tag; } item_t;
  item_t q[$];
  event  obs_ev, obs_done;
  int    n_run = 0, n_fail = 0;
  bit    finished = 1'b0;

  // Monitor: pops expected items and compares to the live outputs.
  initial forever begin
    @(obs_ev);
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      case (it.sel)
        OBS_RDATA:   act = bus_rdata;
        OBS_INHIBIT: act = {7'd0, req_inhibit};
        OBS_BOOTP:   act = {7'd0, boot_protect};
        default:     act = test_bits;
      endcase
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: got %02h expected %02h", it.tag, act, it.exp);
      end
    end
    -> obs_done;
  end

  task automatic push_and_wait(input obs_e s, input logic [7:0] e, input string tag);
    item_t it;
    it.sel = s; it.exp = e; it.tag = tag;
    q.push_back(it);
    -> obs_ev;
    @(obs_done);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic expect_read(input logic [1:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    bus_addr = a;
    push_and_wait(OBS_RDATA, e, tag);
  endtask

  task automatic expect_req(input logic v, input logic [15:0] ad, input logic e, input string tag);
    @(negedge clk);
    req_valid = v; req_addr = ad;
    push_and_wait(OBS_INHIBIT, {7'd0, e}, tag);
    req_valid = 1'b0;
  endtask

  task automatic expect_out(input obs_e s, input logic [7:0] e, input string tag);
    @(negedge clk);
    push_and_wait(s, e, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #40000;
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R2 / R1: reset values through the bus
    expect_read(2'd0, 8'h00, "R2 lock reset");
    expect_read(2'd1, 8'h01, "R2 bootp reset");
    expect_read(2'd2, 8'h00, "R2 test reset");
    expect_out(OBS_BOOTP, 8'h01, "R2 bootp port");

    // R7 / R6: window edges in all four settings
    map_high = 1'b0; small_boot = 1'b0;
    expect_req(1'b1, 16'h7800, 1'b1, "R7 low 2K bottom");
    expect_req(1'b1, 16'h77FF, 1'b0, "R7 low 2K below");
    expect_req(1'b1, 16'h7FFF, 1'b1, "R7 low 2K top");
    expect_req(1'b1, 16'hF800, 1'b0, "R7 low map other half");
    expect_req(1'b0, 16'h7900, 1'b0, "R6 no request");
    small_boot = 1'b1;
    expect_req(1'b1, 16'h7BFF, 1'b0, "R7 low 1K below");
    expect_req(1'b1, 16'h7C00, 1'b1, "R7 low 1K bottom");
    map_high = 1'b1;
    expect_req(1'b1, 16'hFC00, 1'b1, "R7 high 1K bottom");
    expect_req(1'b1, 16'hFBFF, 1'b0, "R7 high 1K below");
    expect_req(1'b1, 16'h7FFF, 1'b0, "R7 high map other half");
    small_boot = 1'b0;
    expect_req(1'b1, 16'hF800, 1'b1, "R7 high 2K bottom");
    expect_req(1'b1, 16'hF7FF, 1'b0, "R7 high 2K below");

    // R5: program-enable blocks, then write goes through
    prog_en = 1'b1;
    bus_write(2'd1, 8'h00);
    expect_read(2'd1, 8'h01, "R5 blocked by prog_en");
    prog_en = 1'b0;
    bus_write(2'd1, 8'h00);
    expect_read(2'd1, 8'h00, "R5 write accepted");
    expect_req(1'b1, 16'hF800, 1'b0, "R6 bootp off passes");
    bus_write(2'd1, 8'hFF);
    expect_read(2'd1, 8'h01, "R1 cfg upper bits zero");

    // R8: test register in both modes
    bus_write(2'd2, 8'hA5);
    expect_read(2'd2, 8'h00, "R8 normal read zero");
    expect_out(OBS_TEST, 8'h00, "R8 normal port zero");
    special_mode = 1'b1;
    expect_read(2'd2, 8'h00, "R8 normal write dropped");
    bus_write(2'd2, 8'hA5);
    expect_read(2'd2, 8'hA5, "R8 special readback");
    expect_out(OBS_TEST, 8'hA5, "R8 special port");
    special_mode = 1'b0;
    expect_read(2'd2, 8'h00, "R8 hidden again");

    // R4: repeated lock writes in special mode
    special_mode = 1'b1;
    bus_write(2'd0, 8'h01);
    expect_read(2'd0, 8'h01, "R4 set");
    bus_write(2'd0, 8'h00);
    expect_read(2'd0, 8'h00, "R4 clear");
    bus_write(2'd0, 8'hFF);
    expect_read(2'd0, 8'h01, "R4 set again, R1 lock upper bits");
    bus_write(2'd0, 8'h00);
    expect_read(2'd0, 8'h00, "R4 clear again");
    special_mode = 1'b0;

    // R3 / R5: first normal write locks, later ones ignored
    bus_write(2'd0, 8'h01);
    expect_read(2'd0, 8'h01, "R3 first write");
    bus_write(2'd1, 8'h00);
    expect_read(2'd1, 8'h01, "R5 blocked by lock");
    bus_write(2'd0, 8'h00);
    expect_read(2'd0, 8'h01, "R3 second write ignored");

    // R9: unmapped offset
    bus_write(2'd3, 8'hFF);
    expect_read(2'd3, 8'h00, "R9 unmapped read");
    expect_read(2'd0, 8'h01, "R9 lock untouched");
    expect_read(2'd1, 8'h01, "R9 cfg untouched");

    // R3: a first write of zero still consumes the single chance
    do_reset();
    expect_read(2'd0, 8'h00, "R2 lock after reset");
    bus_write(2'd0, 8'h00);
    bus_write(2'd0, 8'h01);
    expect_read(2'd0, 8'h00, "R3 zero write consumed");
    bus_write(2'd1, 8'h00);
    expect_read(2'd1, 8'h00, "R5 unlocked write");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule